// File: doc/BRIEF.md
# Byte-Wide Random Byte Register Window

This block is a small memory-mapped window in front of a random-bit source. The window is three bytes wide and sits on a simple synchronous byte bus with an address, a write strobe, a read strobe and write and read data. The first byte reports that the generator exists and holds its on/off switch. The second byte tells software whether a fresh random byte is waiting. The third byte hands that byte out. Software checks for presence, switches the generator on and confirms the switch by reading it back. It then polls the status byte and reads one random byte whenever one is flagged.

Entropy arrives as a serial bit stream on a valid/ready input. A bit moves only in a cycle where both valid and ready are high. The block raises ready only while it is switched on and holds no unread byte. A full byte therefore back-pressures the source until software takes the byte, and the source must hold its bit until ready is seen. The block samples no noise and runs no health tests. It only collects the bits, packs them into bytes and exposes them.

Top module: `rng_regwin`

## Requirements
- R1: After reset the enable bit is 0, the data-ready flag is 0 and `ent_ready` is 0.
- R2: A read of offset 0 returns 0x40 with bit 0 set to the current enable value, and all other bits are 0. Read data is valid in the same cycle as `bus_rd`, and `bus_rdata` is 0 when `bus_rd` is low.
- R3: A write to offset 0 loads bit 0 of the write data into the enable bit and ignores the other bits. A read of offset 0 in the next cycle returns the new enable value.
- R4: Writes to offsets 1, 2 and 3 change neither the enable bit, nor the data-ready flag, nor the held data byte.
- R5: `ent_ready` is 1 exactly when the block is enabled and the data-ready flag is 0. A bit is taken only on a cycle where `ent_valid` and `ent_ready` are both high.
- R6: After eight accepted bits, bit 0 of offset 1 reads 1 and the other bits of offset 1 read 0. Offset 2 then returns those bits packed with the first accepted bit in bit 7 and the last in bit 0.
- R7: A read of offset 2 clears the data-ready flag. The flag sets again only after eight more bits have been accepted.
- R8: Clearing the enable bit clears the data-ready flag, drops any partly collected bits and keeps the last complete byte at offset 2. After re-enabling, eight new bits are needed before data-ready sets.
- R9: If a write that clears the enable bit lands in the same cycle as the eighth accepted bit, the disable wins. The new byte is dropped, data-ready stays 0 and offset 2 keeps the older byte.
- R10: A read of offset 1 has no side effect on data-ready, and a read of offset 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Byte offset within the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| ent_valid | input | 1 | Entropy bit valid |
| ent_bit | input | 1 | Entropy bit value |
| ent_ready | output | 1 | Block accepts an entropy bit this cycle |

## Verification
The sharpest overlap is a bus write that switches the generator off in the same cycle as the eighth entropy bit is accepted. It is provoked by feeding seven bits and then driving the eighth bit and the disabling write on one clock edge. The outcome is judged by reading that data-ready is 0 and that offset 2 still returns the previously completed byte. A second overlap checks that a source holding valid high against a full byte moves no bits until the byte is read. It also checks that the read itself reopens `ent_ready` for the next byte. Random bytes fed with random idle gaps are compared against bytes packed by a bench function.

// File: rtl/rng_regwin_pkg.sv
package rng_regwin_pkg;
  localparam int ADDR_W = 2;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_DATA = 2'd2;

  localparam int CTRL_PRESENT_BIT = 6;
  localparam int CTRL_ENABLE_BIT  = 0;
  localparam int STAT_READY_BIT   = 0;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } win_sel_e;
endpackage

// File: rtl/rng_enable_reg.sv
module rng_enable_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wr_bit,
  output logic en_q,
  output logic en_next
);
  always_comb begin
    en_next = en_q;
    if (wr_hit) en_next = wr_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_next;
  end

  // enable reflects the last write to offset 0 in the following cycle
  assert_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (en_q == $past(wr_bit)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(en_q));
endmodule

// File: rtl/rng_bit_collector.sv
module rng_bit_collector #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_q,
  input  logic              en_next,
  input  logic              rd_take,
  input  logic              in_valid,
  input  logic              in_bit,
  output logic              in_ready,
  output logic              dready,
  output logic [DATA_W-1:0] data_q
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shift_q;
  logic [DATA_W-1:0] shift_nx;
  logic              take;
  logic              finish;

  assign in_ready = en_q && !dready;
  assign take     = in_valid && in_ready;
  assign finish   = take && (cnt_q == LAST);

  generate
    if (DATA_W > 1) begin : g_wide
      assign shift_nx = {shift_q[DATA_W-2:0], in_bit};
    end else begin : g_single
      assign shift_nx = in_bit;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      shift_q <= '0;
      data_q  <= '0;
      dready  <= 1'b0;
    end else if (!en_next) begin
      cnt_q  <= '0;
      dready <= 1'b0;
    end else begin
      if (rd_take) dready <= 1'b0;
      if (take) begin
        shift_q <= shift_nx;
        if (finish) begin
          data_q <= shift_nx;
          dready <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_off_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !dready);

  assert_off_data_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(data_q));

  assert_disable_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_next |=> !dready);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && dready) |=> !dready);

  assert_no_take_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dready |-> !in_ready);
endmodule

// File: rtl/rng_read_mux.sv
module rng_read_mux
  import rng_regwin_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en_q,
  input  logic              dready,
  input  logic [DATA_W-1:0] data_q,
  output logic [BYTE_W-1:0] rdata
);
  win_sel_e sel;

  always_comb begin
    case (addr)
      OFS_CTRL: sel = SEL_CTRL;
      OFS_STAT: sel = SEL_STAT;
      OFS_DATA: sel = SEL_DATA;
      default:  sel = SEL_NONE;
    endcase
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (sel)
        SEL_CTRL: begin
          rdata[CTRL_PRESENT_BIT] = 1'b1;
          rdata[CTRL_ENABLE_BIT]  = en_q;
        end
        SEL_STAT: rdata[STAT_READY_BIT] = dready;
        SEL_DATA: rdata = BYTE_W'(data_q);
        SEL_NONE: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/rng_regwin.sv
module rng_regwin
  import rng_regwin_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              ent_valid,
  input  logic              ent_bit,
  output logic              ent_ready
);
  logic              en_q;
  logic              en_next;
  logic              dready;
  logic [DATA_W-1:0] data_q;
  logic              ctrl_wr;
  logic              data_rd;
  logic              unused_wdata_bits;

  assign ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);
  assign data_rd = bus_rd && (bus_addr == OFS_DATA);
  assign unused_wdata_bits = ^{bus_wdata[BYTE_W-1:CTRL_ENABLE_BIT+1]};

  rng_enable_reg u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (ctrl_wr),
    .wr_bit  (bus_wdata[CTRL_ENABLE_BIT]),
    .en_q    (en_q),
    .en_next (en_next)
  );

  rng_bit_collector #(.DATA_W(DATA_W)) u_col (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_q     (en_q),
    .en_next  (en_next),
    .rd_take  (data_rd),
    .in_valid (ent_valid),
    .in_bit   (ent_bit),
    .in_ready (ent_ready),
    .dready   (dready),
    .data_q   (data_q)
  );

  rng_read_mux #(.DATA_W(DATA_W)) u_mux (
    .rd     (bus_rd),
    .addr   (bus_addr),
    .en_q   (en_q),
    .dready (dready),
    .data_q (data_q),
    .rdata  (bus_rdata)
  );

  assert_ctrl_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_CTRL) |-> (bus_rdata == {1'b0, 1'b1, 5'b0, en_q}));

  assert_idle_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));

  assert_other_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != OFS_CTRL && !ent_ready && !data_rd) |=> $stable(dready));

  assert_stat_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_STAT && !bus_wr && dready) |=> dready);
endmodule

// File: tb/rng_regwin_test.sv
`timescale 1ns/1ps
module rng_regwin_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       ent_valid = 1'b0;
  logic       ent_bit = 1'b0;
  logic       ent_ready;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rng_regwin uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .ent_valid(ent_valid), .ent_bit(ent_bit), .ent_ready(ent_ready)
  );

  function automatic logic [7:0] pack_bits(input logic [7:0] seq);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) r = {r[6:0], seq[7-i]};
    return r;
  endfunction

  function automatic logic [7:0] ctrl_expect(input logic en);
    return {1'b0, 1'b1, 5'b0, en};
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic push(input logic b, input int gap);
    for (int g = 0; g < gap; g++) @(negedge clk);
    @(negedge clk);
    ent_valid = 1'b1; ent_bit = b;
    #1 check({7'b0, ent_ready}, 8'h01, "R5 ready while collecting");
    @(posedge clk); #1;
    ent_valid = 1'b0;
  endtask

  task automatic feed(input logic [7:0] seq, input bit gaps);
    for (int i = 7; i >= 0; i--) push(seq[i], gaps ? int'($urandom_range(0, 3)) : 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] last;
    logic [7:0] s;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    #1 check({7'b0, ent_ready}, 8'h00, "R1 ent_ready after reset");
    rd(2'd0, v); check(v, ctrl_expect(1'b0), "R1 enable after reset");
    rd(2'd1, v); check(v, 8'h00, "R1 data-ready after reset");
    @(negedge clk); #1 check(bus_rdata, 8'h00, "R2 idle read bus");

    // R4 writes elsewhere do nothing
    wr(2'd1, 8'hFF); wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
    rd(2'd0, v); check(v, ctrl_expect(1'b0), "R4 enable untouched");

    // R3 enable with junk in other bits
    wr(2'd0, 8'hFE);
    rd(2'd0, v); check(v, ctrl_expect(1'b0), "R3 bit0 clear keeps off");
    wr(2'd0, 8'hA5);
    rd(2'd0, v); check(v, ctrl_expect(1'b1), "R3 readback enabled");

    // R6 first byte, directed pattern
    s = 8'b1000_0001;
    feed(s, 0);
    rd(2'd1, v); check(v, 8'h01, "R6 status ready");
    rd(2'd1, v); check(v, 8'h01, "R10 status read no side effect");
    rd(2'd3, v); check(v, 8'h00, "R10 offset 3 reads zero");

    // R5 back-pressure while full
    @(negedge clk); ent_valid = 1'b1; ent_bit = 1'b0;
    #1 check({7'b0, ent_ready}, 8'h00, "R5 ready low when full");
    repeat (4) @(posedge clk);
    #1 ent_valid = 1'b0;
    wr(2'd2, 8'h00); wr(2'd1, 8'h00);
    rd(2'd1, v); check(v, 8'h01, "R4 status kept after writes");
    rd(2'd2, v); check(v, pack_bits(s), "R6 data byte");
    last = pack_bits(s);
    rd(2'd1, v); check(v, 8'h00, "R7 read clears ready");

    // R7 random bytes with idle gaps
    for (int k = 0; k < 20; k++) begin
      s = 8'($urandom());
      feed(s, 1);
      rd(2'd1, v); check(v, 8'h01, "R7 ready after eight bits");
      rd(2'd2, v); check(v, pack_bits(s), "R6 random byte");
      last = pack_bits(s);
    end

    // R7 seven bits are not enough
    feed_partial: for (int i = 0; i < 7; i++) push(1'b1, 0);
    rd(2'd1, v); check(v, 8'h00, "R7 seven bits not ready");
    // R8 disable drops partial bits, data kept
    wr(2'd0, 8'h00);
    #1 check({7'b0, ent_ready}, 8'h00, "R8 ready low when off");
    rd(2'd2, v); check(v, last, "R8 data kept when off");
    wr(2'd0, 8'h01);
    push(1'b0, 0);
    rd(2'd1, v); check(v, 8'h00, "R8 partial bits dropped");
    s = 8'h3C;
    for (int i = 6; i >= 0; i--) push(s[i], 0);
    rd(2'd1, v); check(v, 8'h01, "R8 ready after eight fresh bits");
    rd(2'd2, v); check(v, pack_bits({1'b0, s[6:0]}), "R8 fresh byte");
    last = pack_bits({1'b0, s[6:0]});

    // R8 disable with a full byte clears ready
    feed(8'h5A, 0);
    wr(2'd0, 8'h00);
    rd(2'd1, v); check(v, 8'h00, "R8 disable clears ready");
    rd(2'd2, v); check(v, pack_bits(8'h5A), "R8 full byte kept on disable");
    last = pack_bits(8'h5A);
    wr(2'd0, 8'h01);

    // R9 disable lands with the eighth bit
    s = 8'hC3;
    for (int i = 7; i >= 1; i--) push(s[i], 0);
    @(negedge clk);
    ent_valid = 1'b1; ent_bit = s[0];
    bus_addr = 2'd0; bus_wdata = 8'h00; bus_wr = 1'b1;
    @(posedge clk); #1;
    ent_valid = 1'b0; bus_wr = 1'b0;
    rd(2'd1, v); check(v, 8'h00, "R9 ready stays low");
    rd(2'd2, v); check(v, last, "R9 older byte kept");
    rd(2'd0, v); check(v, ctrl_expect(1'b0), "R9 disabled");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule